// File: doc/BRIEF.md
# Carrier Sense and Collision Indicator

This block drives the carrier sense (`crs`) and collision (`col`) status lines that a 10/100 Ethernet physical layer presents to its MAC on the nibble-wide media independent interface. Its inputs are the MAC's transmit enable and a pre-qualified receive-activity flag for 10 Mb/s. For 100 Mb/s it also takes a signal-detect flag and the descrambled serial receive bit stream. It further takes the speed and duplex selects, a heartbeat enable, and a single-cycle strobe that marks each bit time at the current speed.

Carrier is reported for receive activity in every mode. In half duplex it is also reported for transmit activity. At 100 Mb/s, receive carrier locks once two non-adjacent zero bits are seen while signal detect holds. It releases after a run of idle (one) bits, or as soon as signal detect drops. A collision is simultaneous transmit and receive activity in half duplex. It is reported at once when it starts during reception or at 100 Mb/s. When it starts during a 10 Mb/s transmission, it is reported only after it has persisted for a number of bit times. After each 10 Mb/s transmission, an optional heartbeat pulse is placed on `col` following a short gap.

Top module: `mii_crs_col`

## Requirements
- R1: A synchronous active-high `rst` clears `crs` and `col` on the next clock edge. It also abandons any pending collision count and heartbeat timer, so no stale `col` pulse follows the reset.
- R2: At 10 Mb/s in half duplex, `crs` is high one clock after `tx_en` or `rx_active` is high. It is low one clock after both are low.
- R3: In full duplex, `crs` follows receive carrier only, and `tx_en` has no effect on it.
- R4: At 100 Mb/s, with `sig_det` high, receive carrier locks on the strobed bit that completes a pattern of a zero, at least one later one, and then another zero. Two adjacent zeros alone do not lock it. Bits strobed while `sig_det` is low are ignored. `crs` follows two clocks after the strobe.
- R5: A locked 100 Mb/s carrier releases after IDLE_RUN consecutive strobed ones (default 10), or one clock after `sig_det` falls. Every new lock then needs a fresh zero–one–zero pattern.
- R6: In full duplex `col` never reports a collision.
- R7: If receive activity appears at 10 Mb/s while `tx_en` was already high, `col` rises only on the DLY_BITS-th strobe (default 7) counted while the collision lasts. If the collision breaks off, the count restarts.
- R8: A collision that starts while receiving, or any collision at 100 Mb/s, raises `col` one clock after the collision condition appears.
- R9: `col` stays high while the collision condition lasts. It falls one clock after the condition ends, unless a heartbeat pulse is active.
- R10: With `hb_en` high at 10 Mb/s, the fall of `tx_en` starts a gap of GAP_BITS strobes (default 10). Then `col` is high for PULSE_BITS strobes (default 10).
- R11: No heartbeat pulse is issued when `hb_en` is low, when the link runs at 100 Mb/s, or when `tx_en` rises again during the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| rx_active | input | 1 | Squelch-qualified receive activity, used at 10 Mb/s |
| sig_det | input | 1 | Signal detect, used at 100 Mb/s |
| rx_bit | input | 1 | Serial received bit, sampled with `bit_stb` at 100 Mb/s |
| speed_100 | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| full_duplex | input | 1 | 1 selects full duplex, 0 selects half duplex |
| hb_en | input | 1 | Heartbeat enable |
| bit_stb | input | 1 | One-clock strobe per bit time |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision indication, including the heartbeat pulse |

## Verification
The bench builds the block with its default parameters: a seven-strobe collision delay, a ten-strobe heartbeat gap and pulse, and a ten-one idle run to release the 100 Mb/s carrier. At these sizes every window can be walked strobe by strobe in a few hundred clocks. The bench checks each window one strobe before and exactly at its boundary. This covers the collision delay, where the count restarts after an interrupted collision, the start and end of the heartbeat, and the release of carrier after the idle run.

// File: rtl/crs_col_pkg.sv
package crs_col_pkg;

    typedef struct packed {
        logic fast;   // 1: 100 Mb/s
        logic full;   // 1: full duplex
    } link_mode_t;

    typedef enum logic [1:0] {
        CT_IDLE,
        CT_WAIT,
        CT_HIT
    } col_st_e;

    typedef enum logic [1:0] {
        HB_IDLE,
        HB_GAP,
        HB_PULSE
    } hb_st_e;

    function automatic logic crs_want(link_mode_t m, logic tx, logic rx);
        return rx | (tx & ~m.full);
    endfunction

    function automatic logic clash(link_mode_t m, logic tx, logic rx);
        return tx & rx & ~m.full;
    endfunction

endpackage

// File: rtl/cs_lock100.sv
module cs_lock100 #(
    parameter int IDLE_RUN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic sig_det,
    input  logic bit_in,
    output logic car
);
    localparam int RW = $clog2(IDLE_RUN + 1);

    logic          zero_a;
    logic          gap_one;
    logic [RW-1:0] ones;

    always_ff @(posedge clk) begin
        if (rst || !sig_det) begin
            car     <= 1'b0;
            zero_a  <= 1'b0;
            gap_one <= 1'b0;
            ones    <= '0;
        end else if (stb) begin
            if (!car) begin
                if (!bit_in) begin
                    if (zero_a && gap_one) begin
                        car  <= 1'b1;
                        ones <= '0;
                    end else begin
                        zero_a <= 1'b1;
                    end
                end else if (zero_a) begin
                    gap_one <= 1'b1;
                end
            end else if (bit_in) begin
                if (ones == RW'(IDLE_RUN - 1)) begin
                    car     <= 1'b0;
                    zero_a  <= 1'b0;
                    gap_one <= 1'b0;
                    ones    <= '0;
                end else begin
                    ones <= ones + 1'b1;
                end
            end else begin
                ones <= '0;
            end
        end
    end
endmodule

// File: rtl/col_timer.sv
module col_timer
    import crs_col_pkg::*;
#(
    parameter int DLY_BITS = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic cond,
    input  logic defer,
    input  logic fast,
    output logic active
);
    localparam int CW = $clog2(DLY_BITS + 1);

    col_st_e       st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !cond) begin
            st  <= CT_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                CT_IDLE: begin
                    st  <= defer ? CT_WAIT : CT_HIT;
                    cnt <= '0;
                end
                CT_WAIT: begin
                    if (fast) begin
                        st <= CT_HIT;
                    end else if (stb) begin
                        if (cnt == CW'(DLY_BITS - 1)) st <= CT_HIT;
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign active = (st == CT_HIT);
endmodule

// File: rtl/sqe_gen.sv
module sqe_gen
    import crs_col_pkg::*;
#(
    parameter int GAP_BITS   = 10,
    parameter int PULSE_BITS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic tx_en,
    input  logic tx_fall,
    input  logic allow,
    output logic pulse
);
    localparam int MAXB = (GAP_BITS > PULSE_BITS) ? GAP_BITS : PULSE_BITS;
    localparam int CW   = $clog2(MAXB + 1);

    hb_st_e        st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= HB_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                HB_IDLE: begin
                    cnt <= '0;
                    if (tx_fall && allow) st <= HB_GAP;
                end
                HB_GAP: begin
                    if (tx_en || !allow) begin
                        st  <= HB_IDLE;
                        cnt <= '0;
                    end else if (stb) begin
                        if (cnt == CW'(GAP_BITS - 1)) begin
                            st  <= HB_PULSE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                HB_PULSE: begin
                    if (stb) begin
                        if (cnt == CW'(PULSE_BITS - 1)) begin
                            st  <= HB_IDLE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    st  <= HB_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    assign pulse = (st == HB_PULSE);
endmodule

// File: rtl/mii_crs_col.sv
module mii_crs_col
    import crs_col_pkg::*;
#(
    parameter int DLY_BITS   = 7,
    parameter int GAP_BITS   = 10,
    parameter int PULSE_BITS = 10,
    parameter int IDLE_RUN   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic rx_active,
    input  logic sig_det,
    input  logic rx_bit,
    input  logic speed_100,
    input  logic full_duplex,
    input  logic hb_en,
    input  logic bit_stb,
    output logic crs,
    output logic col
);
    link_mode_t mode;
    logic       car100;
    logic       rx_car;
    logic       tx_prev;
    logic       coll_cond;
    logic       coll_active;
    logic       sqe_pulse;

    assign mode.fast = speed_100;
    assign mode.full = full_duplex;

    cs_lock100 #(.IDLE_RUN(IDLE_RUN)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .stb    (bit_stb),
        .sig_det(sig_det),
        .bit_in (rx_bit),
        .car    (car100)
    );

    assign rx_car    = mode.fast ? car100 : rx_active;
    assign coll_cond = clash(mode, tx_en, rx_car);

    col_timer #(.DLY_BITS(DLY_BITS)) u_coll (
        .clk   (clk),
        .rst   (rst),
        .stb   (bit_stb),
        .cond  (coll_cond),
        .defer (tx_prev & ~mode.fast),
        .fast  (mode.fast),
        .active(coll_active)
    );

    sqe_gen #(.GAP_BITS(GAP_BITS), .PULSE_BITS(PULSE_BITS)) u_sqe (
        .clk    (clk),
        .rst    (rst),
        .stb    (bit_stb),
        .tx_en  (tx_en),
        .tx_fall(tx_prev & ~tx_en),
        .allow  (hb_en & ~mode.fast),
        .pulse  (sqe_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_prev <= 1'b0;
            crs     <= 1'b0;
        end else begin
            tx_prev <= tx_en;
            crs     <= crs_want(mode, tx_en, rx_car);
        end
    end

    assign col = coll_active | sqe_pulse;
endmodule

// File: rtl/crs_col_chk.sv
module crs_col_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic speed_100,
    input logic full_duplex,
    input logic hb_en,
    input logic bit_stb,
    input logic rx_car,
    input logic tx_prev,
    input logic coll_cond,
    input logic coll_active,
    input logic sqe_pulse,
    input logic crs,
    input logic col
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (!crs && !col));

    // R3
    fd_crs_rx_only_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(full_duplex) && !$past(rx_car)) |-> !crs);

    // R6
    fd_no_coll_chk: assert property (@(posedge clk) disable iff (rst)
        $past(full_duplex) |-> !coll_active);

    // R7
    tx_first_wait_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(coll_active) && $past(tx_prev) && !$past(speed_100)) |-> $past(bit_stb));

    // R8
    fast_immediate_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(coll_cond) && $past(speed_100)) |-> coll_active);

    // R9
    coll_ends_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(coll_cond) |-> !coll_active);

    // R10
    hb_after_tx_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sqe_pulse) |-> !$past(tx_en));

    // R11
    hb_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(sqe_pulse) && $past(speed_100 || !hb_en)) |-> !sqe_pulse);
endmodule

bind mii_crs_col crs_col_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .speed_100  (speed_100),
    .full_duplex(full_duplex),
    .hb_en      (hb_en),
    .bit_stb    (bit_stb),
    .rx_car     (rx_car),
    .tx_prev    (tx_prev),
    .coll_cond  (coll_cond),
    .coll_active(coll_active),
    .sqe_pulse  (sqe_pulse),
    .crs        (crs),
    .col        (col)
);

// File: tb/tb_mii_crs_col.sv
`timescale 1ns/1ps
module tb_mii_crs_col;
    logic clk = 1'b0;
    logic rst, tx_en, rx_active, sig_det, rx_bit, speed_100, full_duplex, hb_en, bit_stb;
    logic crs, col;
    int   n_chk = 0;
    int   n_fail = 0;

    always #2.5 clk = ~clk;

    mii_crs_col dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .rx_active(rx_active),
        .sig_det(sig_det), .rx_bit(rx_bit), .speed_100(speed_100),
        .full_duplex(full_duplex), .hb_en(hb_en), .bit_stb(bit_stb),
        .crs(crs), .col(col)
    );

    // {full_duplex, tx_en, rx_active, expected crs, expected col} at 10 Mb/s
    localparam logic [4:0] TBL [8] = '{
        5'b00000, 5'b00110, 5'b01010, 5'b01111,
        5'b10000, 5'b10110, 5'b11000, 5'b11110
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic strobe(input logic b);
        rx_bit  = b;
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic stay;
        rst = 1'b1; tx_en = 0; rx_active = 0; sig_det = 0; rx_bit = 1;
        speed_100 = 0; full_duplex = 0; hb_en = 0; bit_stb = 0;
        tick(); tick();
        check("R1 crs in reset", crs, 1'b0);
        check("R1 col in reset", col, 1'b0);
        rst = 1'b0;
        tick();

        // table walk: R2 R3 R6 R8 at 10 Mb/s
        for (int i = 0; i < 8; i++) begin
            tx_en = 0; rx_active = 0; full_duplex = TBL[i][4];
            tick(); tick();
            tx_en = TBL[i][3]; rx_active = TBL[i][2];
            tick();
            check($sformatf("R2/R3 crs vector %0d", i), crs, TBL[i][1]);
            check($sformatf("R6/R8 col vector %0d", i), col, TBL[i][0]);
        end
        tx_en = 0; rx_active = 0; full_duplex = 0;
        tick(); tick();

        // R7: transmit-first collision at 10 Mb/s
        tx_en = 1; tick(); tick();
        rx_active = 1; tick();
        repeat (6) strobe(1'b1);
        check("R7 col before 7th strobe", col, 1'b0);
        check("R2 crs during collision", crs, 1'b1);
        strobe(1'b1);
        check("R7 col at 7th strobe", col, 1'b1);
        repeat (3) strobe(1'b1);
        check("R9 col held", col, 1'b1);
        rx_active = 0; tick();
        check("R9 col drops", col, 1'b0);
        // R7: interrupted collision restarts the count
        rx_active = 1; tick();
        repeat (4) strobe(1'b1);
        rx_active = 0; tick();
        rx_active = 1; tick();
        repeat (4) strobe(1'b1);
        check("R7 count restarted", col, 1'b0);
        repeat (3) strobe(1'b1);
        check("R7 col after restarted count", col, 1'b1);
        tx_en = 0; rx_active = 0; tick(); tick();
        check("R2 crs idle", crs, 1'b0);

        // R8: receive-first collision at 10 Mb/s
        rx_active = 1; tick(); tick();
        tx_en = 1; tick();
        check("R8 receive-first immediate", col, 1'b1);
        tx_en = 0; rx_active = 0; tick(); tick();

        // 100 Mb/s carrier lock
        speed_100 = 1; sig_det = 1;
        strobe(1); strobe(1); strobe(0); strobe(0); strobe(1);
        check("R4 adjacent zeros no lock", crs, 1'b0);
        strobe(0);
        check("R4 lock on second zero", crs, 1'b1);
        repeat (9) strobe(1'b1);
        check("R5 carrier before idle run", crs, 1'b1);
        strobe(1);
        check("R5 release after idle run", crs, 1'b0);
        strobe(0); strobe(1);
        check("R5 fresh qualification", crs, 1'b0);
        strobe(0);
        check("R4 relock", crs, 1'b1);
        sig_det = 0; tick(); tick();
        check("R5 release on signal loss", crs, 1'b0);
        strobe(0); strobe(1);
        sig_det = 1;
        strobe(0);
        check("R4 bits without signal ignored", crs, 1'b0);
        strobe(1); strobe(0);
        check("R4 lock after signal back", crs, 1'b1);
        repeat (10) strobe(1'b1);
        check("R5 idle release again", crs, 1'b0);

        // R8: transmit-first collision at 100 Mb/s is immediate
        tx_en = 1; tick(); tick();
        strobe(0); strobe(1); strobe(0);
        check("R8 100M collision immediate", col, 1'b1);
        hb_en = 1;
        tx_en = 0; tick();
        check("R9 col drops at tx end", col, 1'b0);
        stay = 1'b0;
        for (int i = 0; i < 25; i++) begin
            strobe(1'b1);
            if (col) stay = 1'b1;
        end
        check("R11 no heartbeat at 100M", stay, 1'b0);

        // heartbeat at 10 Mb/s
        speed_100 = 0; sig_det = 0;
        tx_en = 1; tick(); tick();
        tx_en = 0; tick();
        check("R2 crs off after tx", crs, 1'b0);
        repeat (9) strobe(1'b1);
        check("R10 no pulse during gap", col, 1'b0);
        strobe(1);
        check("R10 pulse starts", col, 1'b1);
        repeat (9) strobe(1'b1);
        check("R10 pulse still high", col, 1'b1);
        strobe(1);
        check("R10 pulse ends", col, 1'b0);

        // R11: new transmission during the gap suppresses it
        tx_en = 1; tick(); tx_en = 0; tick();
        repeat (5) strobe(1'b1);
        tx_en = 1; tick();
        stay = 1'b0;
        for (int i = 0; i < 15; i++) begin
            strobe(1'b1);
            if (col) stay = 1'b1;
        end
        check("R11 suppressed by new tx", stay, 1'b0);
        // R11: heartbeat disabled
        hb_en = 0; tx_en = 0; tick();
        stay = 1'b0;
        for (int i = 0; i < 20; i++) begin
            strobe(1'b1);
            if (col) stay = 1'b1;
        end
        check("R11 no pulse when disabled", stay, 1'b0);

        // R1: reset abandons a pending heartbeat
        hb_en = 1; tx_en = 1; tick(); tx_en = 0; tick();
        repeat (5) strobe(1'b1);
        rst = 1; tick();
        check("R1 crs after mid-gap reset", crs, 1'b0);
        rst = 0;
        stay = 1'b0;
        for (int i = 0; i < 15; i++) begin
            strobe(1'b1);
            if (col) stay = 1'b1;
        end
        check("R1 heartbeat timer cleared", stay, 1'b0);

        finish_run();
    end
endmodule